// File: doc/BRIEF.md
# Mode-Banked Register File

This block holds the architectural register set of a small 32-bit processor core. Sixteen registers are visible at any moment, and which physical storage backs them depends on a 2-bit processor mode. In the fast-interrupt mode the upper registers R8 to R14 switch to a private set. In the normal-interrupt and supervisor modes only R13 and R14 switch, each mode to its own pair. User-mode contents survive untouched while another mode runs. Two combinational read ports and one clocked write port serve the datapath. A separate link port lets a branch-with-link drop its return value into R14 of the current mode in the same cycle as an ordinary write.

R15 is not ordinary storage. It holds a 24-bit word program counter in bits 25:2. The status bits of bits 31:26 and 1:0 come from an outside status block on dedicated pins and are merged in on read. The block drives a 26-bit fetch address built from the counter with the two low bits forced to zero. A one-cycle strobe advances the counter by one word after each fetch. A write to R15 reloads it and takes precedence over the strobe.

Every access completes in the cycle it is presented: reads are combinational and writes land on the next rising edge. No data stream crosses the edge of the block, so all pins are plain level or strobe signals with no valid/ready handshake and no back-pressure.

Top module: `banked_regfile`

## Requirements
- R1: While reset is asserted and right after it is released, the fetch address is zero and every register R0 to R14 reads zero in every mode.
- R2: In user mode (mode 2'b00) a write to Rn (n from 0 to 14) is returned by both read ports for Rn from the cycle after the write.
- R3: In fast-interrupt mode (mode 2'b01) R8 to R14 are private copies, while R0 to R7 are shared with user mode.
- R4: In normal-interrupt mode (mode 2'b10) and supervisor mode (mode 2'b11) R13 and R14 are private to each of those modes, while R0 to R12 are the user-mode registers.
- R5: User-mode registers keep their values while another mode writes its own copies, and they read unchanged after a return to user mode.
- R6: A read of R15 returns status_hi in bits 31:26, the program counter in bits 25:2 and status_lo in bits 1:0.
- R7: fetch_addr equals the program counter shifted left by two, with bits 1:0 always zero.
- R8: A cycle with fetch_adv high and no write to R15 adds 4 to fetch_addr on the next cycle, wrapping modulo 2^26.
- R9: A write to R15 loads bits 25:2 of wr_data into the program counter, discards the other bits, and overrides fetch_adv in the same cycle.
- R10: link_en writes link_data into the R14 copy that belongs to the current mode.
- R11: When the write port targets R14 in the same cycle as link_en, the write-port data is kept. When the write port targets another register, both writes take effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| mode | input | 2 | Processor mode: 00 user, 01 fast interrupt, 10 interrupt, 11 supervisor |
| rd_a_idx | input | 4 | Read port A register number |
| rd_a_data | output | 32 | Read port A data |
| rd_b_idx | input | 4 | Read port B register number |
| rd_b_data | output | 32 | Read port B data |
| wr_en | input | 1 | Write port strobe |
| wr_idx | input | 4 | Write port register number |
| wr_data | input | 32 | Write port data |
| link_en | input | 1 | Link strobe: write link_data to R14 of the current mode |
| link_data | input | 32 | Return value for the link write |
| status_hi | input | 6 | Status bits shown in R15 bits 31:26 |
| status_lo | input | 2 | Status bits shown in R15 bits 1:0 |
| fetch_adv | input | 1 | Advance the program counter by one word |
| fetch_addr | output | 26 | Byte address of the next instruction fetch |

## Verification
The bench writes a register in one mode and reads the same number in the others. A bank decoder that maps R8 in fast-interrupt mode, or R13 in interrupt mode, onto the user copy would return the other mode's value, and one that maps R12 or R7 privately would read zero instead of the shared value. It drives a write to R15 together with an advance strobe, and runs the counter from its top value through the wrap. A design that lets the advance win, keeps stray low or high data bits, or widens the counter would show the wrong fetch address. It also drives the write port and the link port at R14 in the same cycle and then at different registers. A reversed priority keeps the link value, and a design that blocks the link on any write loses the return value.

// File: rtl/rf_pkg.sv
package rf_pkg;
  typedef enum logic [1:0] {
    MODE_USR  = 2'b00,
    MODE_FAST = 2'b01,
    MODE_IRQ  = 2'b10,
    MODE_SUP  = 2'b11
  } rf_mode_e;
endpackage

// File: rtl/rf_bank_map.sv
// Translates an architectural register number into a physical slot index.
// Slot layout: user R0..R14 first, then the fast-interrupt set, then the
// interrupt pair, then the supervisor pair.
module rf_bank_map #(
  parameter int IDX_W      = 4,
  parameter int PHYS_W     = 5,
  parameter int FAST_FIRST = 8
) (
  input  logic [1:0]        mode,
  input  logic [IDX_W-1:0]  arch_idx,
  output logic [PHYS_W-1:0] phys_idx
);
  import rf_pkg::*;

  localparam int LINK      = (1 << IDX_W) - 2;
  localparam int STK       = LINK - 1;
  localparam int USR_N     = LINK + 1;
  localparam int FAST_BASE = USR_N;
  localparam int IRQ_BASE  = FAST_BASE + LINK - FAST_FIRST + 1;
  localparam int SUP_BASE  = IRQ_BASE + 2;

  logic in_fast, in_pair;

  assign in_fast = (arch_idx >= IDX_W'(FAST_FIRST)) && (arch_idx <= IDX_W'(LINK));
  assign in_pair = (arch_idx >= IDX_W'(STK)) && (arch_idx <= IDX_W'(LINK));

  always_comb begin
    phys_idx = PHYS_W'(arch_idx);
    case (mode)
      MODE_FAST: if (in_fast) phys_idx = PHYS_W'(FAST_BASE - FAST_FIRST) + PHYS_W'(arch_idx);
      MODE_IRQ:  if (in_pair) phys_idx = PHYS_W'(IRQ_BASE - STK) + PHYS_W'(arch_idx);
      MODE_SUP:  if (in_pair) phys_idx = PHYS_W'(SUP_BASE - STK) + PHYS_W'(arch_idx);
      default:   phys_idx = PHYS_W'(arch_idx);
    endcase
  end
endmodule

// File: rtl/rf_storage.sv
// Physical register slots: two prioritized write ports, two read ports.
module rf_storage #(
  parameter int DATA_W = 32,
  parameter int DEPTH  = 26,
  parameter int PHYS_W = 5
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              pri_en,
  input  logic [PHYS_W-1:0] pri_idx,
  input  logic [DATA_W-1:0] pri_data,
  input  logic              sec_en,
  input  logic [PHYS_W-1:0] sec_idx,
  input  logic [DATA_W-1:0] sec_data,
  input  logic [PHYS_W-1:0] ra_idx,
  output logic [DATA_W-1:0] ra_data,
  input  logic [PHYS_W-1:0] rb_idx,
  output logic [DATA_W-1:0] rb_data
);
  logic [DATA_W-1:0] slot [DEPTH];

  always_ff @(posedge clk) begin
    for (int i = 0; i < DEPTH; i++) begin
      if (!rst_n)
        slot[i] <= '0;
      else if (pri_en && pri_idx == PHYS_W'(i))
        slot[i] <= pri_data;
      else if (sec_en && sec_idx == PHYS_W'(i))
        slot[i] <= sec_data;
    end
  end

  assign ra_data = (ra_idx < PHYS_W'(DEPTH)) ? slot[ra_idx] : '0;
  assign rb_data = (rb_idx < PHYS_W'(DEPTH)) ? slot[rb_idx] : '0;
endmodule

// File: rtl/rf_pc.sv
// Word program counter: load has priority over advance.
module rf_pc #(
  parameter int PC_W = 24
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            load_en,
  input  logic [PC_W-1:0] load_val,
  input  logic            adv,
  output logic [PC_W-1:0] pc
);
  always_ff @(posedge clk) begin
    if (!rst_n)       pc <= '0;
    else if (load_en) pc <= load_val;
    else if (adv)     pc <= pc + PC_W'(1);
  end
endmodule

// File: rtl/banked_regfile.sv
module banked_regfile #(
  parameter int DATA_W     = 32,
  parameter int PC_W       = 24,
  parameter int FAST_FIRST = 8
) (
  input  logic                           clk,
  input  logic                           rst_n,
  input  logic [1:0]                     mode,
  input  logic [3:0]                     rd_a_idx,
  output logic [DATA_W-1:0]              rd_a_data,
  input  logic [3:0]                     rd_b_idx,
  output logic [DATA_W-1:0]              rd_b_data,
  input  logic                           wr_en,
  input  logic [3:0]                     wr_idx,
  input  logic [DATA_W-1:0]              wr_data,
  input  logic                           link_en,
  input  logic [DATA_W-1:0]              link_data,
  input  logic [DATA_W-PC_W-3:0]         status_hi,
  input  logic [1:0]                     status_lo,
  input  logic                           fetch_adv,
  output logic [PC_W+1:0]                fetch_addr
);
  localparam int IDX_W   = 4;
  localparam int ADDR_W  = PC_W + 2;
  localparam int PC_IDX  = (1 << IDX_W) - 1;
  localparam int LINK    = PC_IDX - 1;
  localparam int USR_N   = LINK + 1;
  localparam int PHYS_N  = USR_N + (LINK - FAST_FIRST + 1) + 2 + 2;
  localparam int PHYS_W  = $clog2(PHYS_N);
  localparam int NPORT   = 4;

  logic [IDX_W-1:0]  arch_sel [NPORT];
  logic [PHYS_W-1:0] phys_sel [NPORT];

  assign arch_sel[0] = rd_a_idx;
  assign arch_sel[1] = rd_b_idx;
  assign arch_sel[2] = wr_idx;
  assign arch_sel[3] = IDX_W'(LINK);

  for (genvar p = 0; p < NPORT; p++) begin : g_map
    rf_bank_map #(
      .IDX_W(IDX_W), .PHYS_W(PHYS_W), .FAST_FIRST(FAST_FIRST)
    ) u_map (
      .mode(mode), .arch_idx(arch_sel[p]), .phys_idx(phys_sel[p])
    );
  end

  logic              wr_pc, wr_slot;
  logic [DATA_W-1:0] slot_a, slot_b;
  logic [PC_W-1:0]   pc;

  assign wr_pc   = wr_en && (wr_idx == IDX_W'(PC_IDX));
  assign wr_slot = wr_en && !wr_pc;

  rf_storage #(
    .DATA_W(DATA_W), .DEPTH(PHYS_N), .PHYS_W(PHYS_W)
  ) u_store (
    .clk(clk), .rst_n(rst_n),
    .pri_en(wr_slot), .pri_idx(phys_sel[2]), .pri_data(wr_data),
    .sec_en(link_en), .sec_idx(phys_sel[3]), .sec_data(link_data),
    .ra_idx(phys_sel[0]), .ra_data(slot_a),
    .rb_idx(phys_sel[1]), .rb_data(slot_b)
  );

  rf_pc #(.PC_W(PC_W)) u_pc (
    .clk(clk), .rst_n(rst_n),
    .load_en(wr_pc), .load_val(wr_data[ADDR_W-1:2]),
    .adv(fetch_adv), .pc(pc)
  );

  logic [DATA_W-1:0] r15_view;
  assign r15_view   = {status_hi, pc, status_lo};
  assign rd_a_data  = (rd_a_idx == IDX_W'(PC_IDX)) ? r15_view : slot_a;
  assign rd_b_data  = (rd_b_idx == IDX_W'(PC_IDX)) ? r15_view : slot_b;
  assign fetch_addr = {pc, 2'b00};
endmodule

// File: rtl/rf_checker.sv
module rf_checker #(
  parameter int DATA_W = 32,
  parameter int PC_W   = 24
) (
  input logic                   clk,
  input logic                   rst_n,
  input logic [1:0]             mode,
  input logic [3:0]             rd_a_idx,
  input logic [DATA_W-1:0]      rd_a_data,
  input logic                   wr_en,
  input logic [3:0]             wr_idx,
  input logic [DATA_W-1:0]      wr_data,
  input logic                   link_en,
  input logic [DATA_W-1:0]      link_data,
  input logic [DATA_W-PC_W-3:0] status_hi,
  input logic [1:0]             status_lo,
  input logic                   fetch_adv,
  input logic [PC_W+1:0]        fetch_addr
);
  localparam int ADDR_W = PC_W + 2;

  // R1
  a_r1_reset_pc: assert property (@(posedge clk)
    !rst_n |=> fetch_addr == '0);

  // R8
  a_r8_pc_advance: assert property (@(posedge clk) disable iff (!rst_n)
    (fetch_adv && !(wr_en && wr_idx == 4'd15))
      |=> fetch_addr == ADDR_W'($past(fetch_addr) + ADDR_W'(4)));

  // R9
  a_r9_pc_load: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && wr_idx == 4'd15)
      |=> fetch_addr == {$past(wr_data[ADDR_W-1:2]), 2'b00});

  // R6
  a_r6_r15_view: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_a_idx == 4'd15)
      |-> rd_a_data == {status_hi, fetch_addr[ADDR_W-1:2], status_lo});

  // R2
  a_r2_write_visible: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && wr_idx != 4'd15)
      ##1 (rd_a_idx == $past(wr_idx) && mode == $past(mode))
      |-> rd_a_data == $past(wr_data));

  // R10
  a_r10_link_visible: assert property (@(posedge clk) disable iff (!rst_n)
    (link_en && !(wr_en && wr_idx == 4'd14))
      ##1 (rd_a_idx == 4'd14 && mode == $past(mode))
      |-> rd_a_data == $past(link_data));
endmodule

bind banked_regfile rf_checker #(.DATA_W(DATA_W), .PC_W(PC_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .mode(mode),
  .rd_a_idx(rd_a_idx), .rd_a_data(rd_a_data),
  .wr_en(wr_en), .wr_idx(wr_idx), .wr_data(wr_data),
  .link_en(link_en), .link_data(link_data),
  .status_hi(status_hi), .status_lo(status_lo),
  .fetch_adv(fetch_adv), .fetch_addr(fetch_addr)
);

// File: tb/banked_regfile_bench.sv
`timescale 1ns/1ps
module banked_regfile_bench;
  localparam logic [1:0] USR = 2'b00, FST = 2'b01, IRQ = 2'b10, SUP = 2'b11;

  logic        clk = 1'b0;
  logic        rst_n;
  logic [1:0]  mode;
  logic [3:0]  rd_a_idx, rd_b_idx, wr_idx;
  logic [31:0] rd_a_data, rd_b_data, wr_data, link_data;
  logic        wr_en, link_en, fetch_adv;
  logic [5:0]  status_hi;
  logic [1:0]  status_lo;
  logic [25:0] fetch_addr;

  always #2.5 clk = ~clk;

  banked_regfile u_banked_regfile (
    .clk(clk), .rst_n(rst_n), .mode(mode),
    .rd_a_idx(rd_a_idx), .rd_a_data(rd_a_data),
    .rd_b_idx(rd_b_idx), .rd_b_data(rd_b_data),
    .wr_en(wr_en), .wr_idx(wr_idx), .wr_data(wr_data),
    .link_en(link_en), .link_data(link_data),
    .status_hi(status_hi), .status_lo(status_lo),
    .fetch_adv(fetch_adv), .fetch_addr(fetch_addr)
  );

  int checks = 0, failures = 0;
  bit done = 0;

  // scoreboard queues: port select (0 = A, 1 = B, 2 = fetch), value, tag
  int          q_sel [$];
  logic [31:0] q_exp [$];
  string       q_tag [$];

  always @(negedge clk) begin
    while (q_sel.size() > 0) begin
      int          sel;
      logic [31:0] exp, got;
      string       tag;
      sel = q_sel.pop_front();
      exp = q_exp.pop_front();
      tag = q_tag.pop_front();
      case (sel)
        0:       got = rd_a_data;
        1:       got = rd_b_data;
        default: got = {6'b0, fetch_addr};
      endcase
      checks++;
      if (got !== exp) begin
        failures++;
        $display("FAIL %s got=%h exp=%h", tag, got, exp);
      end
    end
  end

  task automatic step();
    @(posedge clk); #1;
    wr_en = 0; link_en = 0; fetch_adv = 0;
  endtask

  task automatic wr(input logic [1:0] m, input logic [3:0] i, input logic [31:0] d);
    mode = m; wr_en = 1; wr_idx = i; wr_data = d;
    step();
  endtask

  task automatic wr_link(input logic [1:0] m, input logic [3:0] i,
                         input logic [31:0] d, input logic [31:0] ld);
    mode = m; wr_en = 1; wr_idx = i; wr_data = d; link_en = 1; link_data = ld;
    step();
  endtask

  task automatic link(input logic [1:0] m, input logic [31:0] ld);
    mode = m; link_en = 1; link_data = ld;
    step();
  endtask

  task automatic adv(input int n);
    for (int k = 0; k < n; k++) begin
      fetch_adv = 1;
      step();
    end
  endtask

  task automatic chk_a(input logic [1:0] m, input logic [3:0] i,
                       input logic [31:0] e, input string tag);
    mode = m; rd_a_idx = i;
    q_sel.push_back(0); q_exp.push_back(e); q_tag.push_back(tag);
    step();
  endtask

  task automatic chk_b(input logic [1:0] m, input logic [3:0] i,
                       input logic [31:0] e, input string tag);
    mode = m; rd_b_idx = i;
    q_sel.push_back(1); q_exp.push_back(e); q_tag.push_back(tag);
    step();
  endtask

  task automatic chk_f(input logic [25:0] e, input string tag);
    q_sel.push_back(2); q_exp.push_back({6'b0, e}); q_tag.push_back(tag);
    step();
  endtask

  initial begin
    rst_n = 0; mode = USR; rd_a_idx = 0; rd_b_idx = 0;
    wr_en = 0; wr_idx = 0; wr_data = 0; link_en = 0; link_data = 0;
    status_hi = 0; status_lo = 0; fetch_adv = 0;
    repeat (3) @(posedge clk);
    #1 rst_n = 1;

    // R1 reset state
    chk_f(26'h0, "R1 fetch after reset");
    chk_a(USR, 4'd0, 32'h0, "R1 user R0");
    chk_b(SUP, 4'd14, 32'h0, "R1 sup R14");
    chk_a(FST, 4'd9, 32'h0, "R1 fast R9");

    // R2 user writes, both ports
    wr(USR, 4'd3, 32'h1111_1111);
    wr(USR, 4'd14, 32'hAAAA_0014);
    wr(USR, 4'd8, 32'h0808_0808);
    wr(USR, 4'd13, 32'h0D0D_0D0D);
    chk_a(USR, 4'd3, 32'h1111_1111, "R2 user R3 port A");
    chk_b(USR, 4'd3, 32'h1111_1111, "R2 user R3 port B");
    chk_b(USR, 4'd14, 32'hAAAA_0014, "R2 user R14 port B");

    // R3 fast-interrupt bank
    wr(FST, 4'd8, 32'h0000_00F8);
    wr(FST, 4'd14, 32'h0000_00FE);
    chk_a(FST, 4'd8, 32'h0000_00F8, "R3 fast R8 private");
    chk_b(FST, 4'd3, 32'h1111_1111, "R3 fast R3 shared");
    chk_a(FST, 4'd13, 32'h0, "R3 fast R13 private unwritten");
    wr(FST, 4'd7, 32'h0707_0707);
    chk_a(USR, 4'd7, 32'h0707_0707, "R3 user R7 shared with fast");

    // R4 interrupt and supervisor pairs
    wr(IRQ, 4'd13, 32'h0000_001D);
    wr(SUP, 4'd13, 32'h0000_005D);
    wr(IRQ, 4'd12, 32'h0000_0012);
    chk_a(IRQ, 4'd13, 32'h0000_001D, "R4 irq R13");
    chk_b(SUP, 4'd13, 32'h0000_005D, "R4 sup R13");
    chk_a(USR, 4'd12, 32'h0000_0012, "R4 irq R12 shared");
    chk_a(FST, 4'd12, 32'h0, "R4 fast R12 private");
    chk_b(IRQ, 4'd8, 32'h0808_0808, "R4 irq R8 is user R8");

    // R5 user copies survive
    chk_a(USR, 4'd8, 32'h0808_0808, "R5 user R8 after fast write");
    chk_b(USR, 4'd13, 32'h0D0D_0D0D, "R5 user R13 after irq/sup write");
    chk_a(USR, 4'd14, 32'hAAAA_0014, "R5 user R14 after fast write");

    // R7 R8 program counter advance
    adv(3);
    chk_f(26'h00_000C, "R8 three advances");
    chk_a(USR, 4'd15, 32'h0000_000C, "R7 R15 low bits zero");

    // R6 status merge
    status_hi = 6'b101011; status_lo = 2'b10;
    chk_b(IRQ, 4'd15, 32'hAC00_000E, "R6 R15 view with status");
    status_hi = 0; status_lo = 0;

    // R9 load beats advance, stray bits dropped
    fetch_adv = 1;
    wr(USR, 4'd15, 32'hFFFF_FF01);
    chk_f(26'h3FF_FF00, "R9 load over advance");
    chk_a(USR, 4'd15, 32'h03FF_FF00, "R9 R15 keeps only bits 25:2");

    // R8 wrap
    wr(USR, 4'd15, 32'h03FF_FFFC);
    chk_f(26'h3FF_FFFC, "R9 load top value");
    adv(1);
    chk_f(26'h0, "R8 wrap to zero");

    // R10 link into current bank
    link(SUP, 32'h0000_005E);
    chk_a(SUP, 4'd14, 32'h0000_005E, "R10 sup R14 link");
    chk_b(USR, 4'd14, 32'hAAAA_0014, "R10 user R14 untouched");
    chk_a(IRQ, 4'd14, 32'h0, "R10 irq R14 untouched");
    chk_b(FST, 4'd14, 32'h0000_00FE, "R10 fast R14 untouched");

    // R11 collisions
    wr_link(IRQ, 4'd14, 32'h0000_0077, 32'h0000_0099);
    chk_a(IRQ, 4'd14, 32'h0000_0077, "R11 write port wins on R14");
    wr_link(IRQ, 4'd2, 32'h0000_0022, 32'h0000_0033);
    chk_a(IRQ, 4'd14, 32'h0000_0033, "R11 link kept when write elsewhere");
    chk_b(USR, 4'd2, 32'h0000_0022, "R11 other write kept");

    step(); step();
    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      checks++;
      failures++;
      $display("FAIL watchdog got=hung exp=finished");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end
endmodule